// File: doc/BRIEF.md
# Constant Off-Time Hysteretic Gate Controller

This block sequences the gate of a power switching transistor in a peak-current, constant off-time converter. Each cycle begins by driving the gate high. The on-time ends when a comparator reports that the sensed switch current has reached the reference. The gate then stays low until an external off-time capacitor crosses its threshold. The controller then discharges that capacitor for a fixed number of clocks and starts the next on-time.

Several protections sit on top of this basic cycle. Both current comparators are masked for a blanking window after each turn-on, so the leading-edge spike cannot end the pulse early. A watchdog forces a new cycle when the off-time threshold never arrives. A trip of the separate current-limit comparator ends the pulse and holds switching off for a long recovery interval.

All three comparator bits pass through two-flop synchronizers. All intervals are given as clock-cycle counts by parameters. With the defaults and a 100 MHz clock, the blanking window is 240 ns, and both the off-time watchdog and the current-limit recovery delay are 280 µs.

Top module: `cot_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, both the gate and discharge outputs are low.
- R2: When enable is sampled low, the gate is low from the next clock on, and no discharge pulse or on-time begins while enable stays low, whatever the comparator inputs do.
- R3: After enable rises, the first activity is a discharge pulse of exactly DIS_CYC cycles, and the gate goes high in the cycle right after that pulse.
- R4: The on-time ends because of the peak comparator. A rising peak bit, applied between clock edges, is seen through two flops: the gate is still high after the second rising edge and low after the third. Without a trip, the on-time does not end.
- R5: During the first BLANK_CYC cycles of each on-time, both the peak and the current-limit bits are ignored. A bit that is already high makes the gate high for exactly BLANK_CYC+1 cycles.
- R6: When the off-time comparator is seen high during the off-time, the off-time ends and a discharge pulse of DIS_CYC cycles follows. The off-time comparator is ignored during that pulse, and the gate rises right after it.
- R7: If the off-time comparator stays low for MAXOFF_CYC cycles of off-time, a discharge pulse and a new on-time are forced. The gate-low gap is then MAXOFF_CYC+DIS_CYC cycles.
- R8: A current-limit bit seen after blanking turns the gate off. The gate stays low for CLREC_CYC cycles, then a discharge pulse of DIS_CYC cycles follows, then a new on-time.
- R9: When the current-limit and peak bits are both high after blanking, the current-limit path (R8) is taken.
- R10: The gate and discharge outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Enables switching; low forces the gate low |
| pk_trip_i | input | 1 | Peak-sense comparator: current has reached the reference |
| cl_trip_i | input | 1 | Current-limit comparator trip |
| off_trip_i | input | 1 | Off-time capacitor has reached its threshold |
| gate_o | output | 1 | Gate drive for the switching transistor |
| dis_o | output | 1 | Discharge pulse for the off-time capacitor |

## Verification
The assertions check several properties on every cycle. The gate and discharge outputs are never high together. A low enable pulls the gate down on the next cycle. Every gate rise follows a discharge cycle. No on-time or discharge pulse shorter than its minimum ends while enable is high. The exact lengths cannot be judged from a single cycle, so the bench's scenarios show them. These cover the watchdog-forced off-time, the threshold-ended off-time, the current-limit recovery gap and its priority over the peak trip, and the two-flop latency from a comparator edge to the gate falling.

// File: rtl/cot_pkg.sv
// Shared types for the constant off-time gate controller.
// Assumes: comparator bits are grouped into one vector in the order given by the index constants.
package cot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DISCH  = 3'd1,
        ST_ON     = 3'd2,
        ST_OFF    = 3'd3,
        ST_CLWAIT = 3'd4
    } cot_state_e;

    // Bit positions inside the synchronized comparator vector
    localparam int CMP_OFF = 0;
    localparam int CMP_PK  = 1;
    localparam int CMP_CL  = 2;
    localparam int CMP_W   = 3;

    // Larger of two integers, used for counter sizing
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cot_sync.sv
// Two-flop synchronizer bank, one chain per bit.
// Assumes: each bit is an independent level; no multi-bit coherency is needed.
module cot_sync #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_chain
        logic meta_q;
        logic stab_q;
        // Shift each bit through two flops; reset clears both
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/cot_interval_ctr.sv
// Cycle counter for the time spent in the present controller state.
// Assumes: clr_i is high on the edge where the state changes, so the count is 0 in a state's first cycle.
module cot_interval_ctr #(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    // Restart on a state change, otherwise count up and saturate
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cot_seq_fsm.sv
// Switching sequencer: discharge, on-time, off-time and current-limit recovery.
// Assumes: comparator bits are already synchronized; cnt_i counts cycles in the present state.
module cot_seq_fsm
    import cot_pkg::*;
#(
    parameter int BLANK_CYC  = 24,
    parameter int DIS_CYC    = 8,
    parameter int MAXOFF_CYC = 28000,
    parameter int CLREC_CYC  = 28000,
    parameter int CW         = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CMP_W-1:0] cmp_i,
    input  logic [CW-1:0]    cnt_i,
    output cot_state_e       state_o,
    output logic             clr_o
);
    localparam logic [CW-1:0] DIS_LAST    = CW'(DIS_CYC - 1);
    localparam logic [CW-1:0] BLANK_END   = CW'(BLANK_CYC);
    localparam logic [CW-1:0] MAXOFF_LAST = CW'(MAXOFF_CYC - 1);
    localparam logic [CW-1:0] CLREC_LAST  = CW'(CLREC_CYC - 1);

    cot_state_e state_q;
    cot_state_e state_d;
    logic       unblanked;

    assign unblanked = (cnt_i >= BLANK_END);

    // Next-state selection; a low enable wins over everything else
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_DISCH;
                ST_DISCH:  if (cnt_i == DIS_LAST) state_d = ST_ON;
                ST_ON: begin
                    if (unblanked && cmp_i[CMP_CL])      state_d = ST_CLWAIT;
                    else if (unblanked && cmp_i[CMP_PK]) state_d = ST_OFF;
                end
                ST_OFF: begin
                    if (cmp_i[CMP_OFF])                  state_d = ST_DISCH;
                    else if (cnt_i == MAXOFF_LAST)       state_d = ST_DISCH;
                end
                ST_CLWAIT: if (cnt_i == CLREC_LAST) state_d = ST_DISCH;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register with synchronous reset to idle
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    assign clr_o   = (state_d != state_q);
    assign state_o = state_q;
endmodule

// File: rtl/cot_gate_ctrl.sv
// Top of the constant off-time hysteretic gate controller.
// Synchronizes the comparator bits, runs the sequencer with a shared state-time counter,
// and decodes the gate drive and capacitor discharge pulse from the state.
// Assumes: every interval parameter is at least 1; enable is already in the clock domain.
module cot_gate_ctrl
    import cot_pkg::*;
#(
    parameter int BLANK_CYC  = 24,
    parameter int DIS_CYC    = 8,
    parameter int MAXOFF_CYC = 28000,
    parameter int CLREC_CYC  = 28000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic pk_trip_i,
    input  logic cl_trip_i,
    input  logic off_trip_i,
    output logic gate_o,
    output logic dis_o
);
    localparam int LONGEST = imax(imax(MAXOFF_CYC, CLREC_CYC), imax(BLANK_CYC + 1, DIS_CYC));
    localparam int CW      = $clog2(LONGEST + 1) + 1;

    logic [CMP_W-1:0] cmp_raw;
    logic [CMP_W-1:0] cmp_s;
    logic [CW-1:0]    cnt;
    logic             clr;
    cot_state_e       state;

    assign cmp_raw[CMP_OFF] = off_trip_i;
    assign cmp_raw[CMP_PK]  = pk_trip_i;
    assign cmp_raw[CMP_CL]  = cl_trip_i;

    cot_sync #(.W(CMP_W)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (cmp_raw),
        .sync_o  (cmp_s)
    );

    cot_interval_ctr #(.CW(CW)) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .cnt_o  (cnt)
    );

    cot_seq_fsm #(
        .BLANK_CYC  (BLANK_CYC),
        .DIS_CYC    (DIS_CYC),
        .MAXOFF_CYC (MAXOFF_CYC),
        .CLREC_CYC  (CLREC_CYC),
        .CW         (CW)
    ) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .cmp_i   (cmp_s),
        .cnt_i   (cnt),
        .state_o (state),
        .clr_o   (clr)
    );

    assign gate_o = (state == ST_ON);
    assign dis_o  = (state == ST_DISCH);
endmodule

// File: rtl/cot_gate_ctrl_chk.sv
// Property checker for the gate controller, attached to the top by bind.
// Assumes: the top's parameters are passed through unchanged.
module cot_gate_ctrl_chk #(
    parameter int BLANK_CYC = 24,
    parameter int DIS_CYC   = 8
) (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic gate_i,
    input logic dis_i
);
    int hi_run;
    int dis_run;

    // Length of the present run of gate-high and discharge-high samples
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hi_run  <= 0;
            dis_run <= 0;
        end else begin
            hi_run  <= gate_i ? hi_run + 1 : 0;
            dis_run <= dis_i ? dis_run + 1 : 0;
        end
    end

    AST_GATE_DIS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(gate_i && dis_i)) else $error("gate and discharge both high"); // R10

    AST_EN_LOW_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !gate_i) else $error("gate high after enable low"); // R2

    AST_DIS_BEFORE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_i) |-> $past(dis_i)) else $error("gate rose without discharge"); // R3

    AST_BLANK_MIN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(gate_i) && $past(en_i)) |-> (hi_run >= BLANK_CYC + 1)) else $error("on-time ended inside blanking"); // R5

    AST_DIS_FULL_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(dis_i) && $past(en_i)) |-> (dis_run == DIS_CYC)) else $error("discharge pulse wrong width"); // R6
endmodule

bind cot_gate_ctrl cot_gate_ctrl_chk #(
    .BLANK_CYC (BLANK_CYC),
    .DIS_CYC   (DIS_CYC)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .gate_i (gate_o),
    .dis_i  (dis_o)
);

// File: tb/cot_gate_ctrl_bench.sv
`timescale 1ns/1ps
module cot_gate_ctrl_bench;
    localparam int BLANK  = 12;
    localparam int DIS    = 3;
    localparam int MAXOFF = 200;
    localparam int CLREC  = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic pk = 1'b0;
    logic cl = 1'b0;
    logic off = 1'b0;
    logic gate;
    logic dis;

    always #10 clk = ~clk;

    cot_gate_ctrl #(
        .BLANK_CYC  (BLANK),
        .DIS_CYC    (DIS),
        .MAXOFF_CYC (MAXOFF),
        .CLREC_CYC  (CLREC)
    ) u_cot_gate_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .pk_trip_i  (pk),
        .cl_trip_i  (cl),
        .off_trip_i (off),
        .gate_o     (gate),
        .dis_o      (dis)
    );

    int tests = 0;
    int fails = 0;
    int both_seen = 0;
    bit arm = 1'b0;
    bit finished = 1'b0;

    // Scoreboard: expected output segments, kind 0 low, 1 discharge, 2 gate
    int    exp_code[$];
    int    exp_len[$];
    string exp_tag[$];

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input string tag, input int code, input int len);
        exp_tag.push_back(tag);
        exp_code.push_back(code);
        exp_len.push_back(len);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle_idle();
        @(negedge clk);
        arm = 1'b0;
        en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic start(input logic p, input logic c, input logic o);
        @(negedge clk);
        pk = p;
        cl = c;
        off = o;
        repeat (4) @(negedge clk);
        en = 1'b1;
        arm = 1'b1;
    endtask

    task automatic drain();
        while (exp_len.size() > 0) @(posedge clk);
    endtask

    task automatic wait_gate();
        int guard = 0;
        do begin
            step();
            guard++;
        end while (!gate && guard < 100);
    endtask

    // Monitor: run-length encode the outputs and compare each finished segment
    initial begin : monitor
        int  cur_code;
        int  cur_len;
        int  code;
        bit  have;
        have = 1'b0;
        cur_code = 0;
        cur_len = 0;
        forever begin
            @(posedge clk);
            #1;
            if (gate && dis) both_seen++;
            if (!arm) begin
                have = 1'b0;
            end else begin
                code = int'({gate, dis});
                if (!have) begin
                    have = 1'b1;
                    cur_code = code;
                    cur_len = 1;
                end else if (code == cur_code) begin
                    cur_len++;
                end else begin
                    if (exp_len.size() > 0) begin
                        string t;
                        int ec;
                        int el;
                        t  = exp_tag.pop_front();
                        ec = exp_code.pop_front();
                        el = exp_len.pop_front();
                        chk({t, " kind"}, cur_code, ec);
                        chk({t, " length"}, cur_len, el);
                    end
                    cur_code = code;
                    cur_len = 1;
                end
            end
        end
    end

    // Watchdog: a hung run is one failed check
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : driver
        int bad;
        // R1: reset holds both outputs low
        rst_n = 1'b0;
        en = 1'b1;
        pk = 1'b1;
        off = 1'b1;
        repeat (3) step();
        chk("R1 gate in reset", int'(gate), 0);
        chk("R1 discharge in reset", int'(dis), 0);
        @(negedge clk);
        en = 1'b0;
        rst_n = 1'b1;
        repeat (3) step();
        chk("R1 gate after reset, enable low", int'(gate), 0);
        chk("R1 discharge after reset, enable low", int'(dis), 0);

        // R3, R5, R7: peak always high, threshold never arrives
        push("R3 first discharge", 1, DIS);
        push("R5 blanked on-time", 2, BLANK + 1);
        push("R7 watchdog off-time", 0, MAXOFF);
        push("R7 forced discharge", 1, DIS);
        push("R5 second on-time", 2, BLANK + 1);
        push("R7 second off-time", 0, MAXOFF);
        push("R3 discharge before gate", 1, DIS);
        start(1'b1, 1'b0, 1'b0);
        drain();
        settle_idle();

        // R6: threshold already high ends off-time at once
        push("R6 first discharge", 1, DIS);
        push("R6 on-time", 2, BLANK + 1);
        push("R6 threshold off-time", 0, 1);
        push("R6 discharge ignores threshold", 1, DIS);
        push("R6 next on-time", 2, BLANK + 1);
        push("R6 second off-time", 0, 1);
        start(1'b1, 1'b0, 1'b1);
        drain();
        settle_idle();

        // R8: current limit, recovery gap
        push("R8 first discharge", 1, DIS);
        push("R8 blanked on-time", 2, BLANK + 1);
        push("R8 recovery gap", 0, CLREC);
        push("R8 discharge after recovery", 1, DIS);
        push("R8 on-time after recovery", 2, BLANK + 1);
        start(1'b0, 1'b1, 1'b1);
        drain();
        settle_idle();

        // R9: limit and peak together take the limit path
        push("R9 first discharge", 1, DIS);
        push("R9 on-time", 2, BLANK + 1);
        push("R9 limit wins gap", 0, CLREC);
        push("R9 discharge", 1, DIS);
        start(1'b1, 1'b1, 1'b0);
        drain();
        settle_idle();

        // R4: peak edge through two flops
        start(1'b0, 1'b0, 1'b1);
        arm = 1'b0;
        wait_gate();
        repeat (20) step();
        chk("R4 on-time holds without trip", int'(gate), 1);
        @(negedge clk);
        pk = 1'b1;
        step();
        step();
        chk("R4 gate still high after second edge", int'(gate), 1);
        step();
        chk("R4 gate low after third edge", int'(gate), 0);
        step();
        chk("R6 discharge after threshold", int'(dis), 1);
        settle_idle();

        // R2: enable low drops the gate and blocks new cycles
        start(1'b0, 1'b0, 1'b1);
        arm = 1'b0;
        wait_gate();
        chk("R2 gate high before enable drop", int'(gate), 1);
        @(negedge clk);
        en = 1'b0;
        step();
        chk("R2 gate low next cycle", int'(gate), 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            pk = i[0];
            off = i[1];
            cl = i[2];
            step();
            if (gate || dis) bad++;
        end
        chk("R2 no activity while disabled", bad, 0);

        chk("R10 gate and discharge never together", both_seen, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule